// File: doc/BRIEF.md
# Write-only serial configuration receiver

This block is a two-wire serial slave that sits beside a clock generator and loads its eight configuration bytes. A host on the bus issues a block write made of eleven bytes: the device address, a command byte and a count byte, then eight data bytes. The command and count bytes are acknowledged and then dropped. Each data byte lands in its own register at the moment it is acknowledged. There is no read path, so the slave drives the data line only to pull it low for an acknowledge.

The two bus lines are brought into a faster system clock through two-flop synchronisers. Start and stop are detected from the synchronised lines, and a small state machine counts bits and bytes and decides which bytes to acknowledge. The register bank resets to defined values, so the clock generator runs correctly even if no write ever happens. From the bank the block decodes the spread-spectrum enable, the 24/48 MHz select for the super-I/O clock and a run mask for sixteen clock outputs. A cleared bit in that mask means the output is held low.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset the register bank holds its defaults: bytes 1 and 2 are 0xFF and all other bytes are 0x00. Byte k appears on `cfg_o[8k+7:8k]`.
- R2: Only the address byte 0xD2, received MSB first, is acknowledged. Any other address byte, including 0xD3, gets no acknowledge, and the rest of that transaction changes no register.
- R3: After a matching address, the second byte (command) and the third byte (count) are acknowledged, and their values change no register.
- R4: Data byte k (k = 0..7, the fourth to eleventh byte) is written into register k. The write takes effect in the same cycle that the acknowledge drive for that byte begins.
- R5: An acknowledge holds `sda_low_o` high from the SCL falling edge that ends bit 8 until the SCL falling edge that ends the ninth clock. After that edge the line is released.
- R6: A byte that follows data byte 7 in the same transaction is not acknowledged and changes no register.
- R7: A stop condition (SDA rising while SCL is high) ends the transaction. A partly received byte is discarded, and bytes clocked later without a new start are neither acknowledged nor stored.
- R8: A start detected in the middle of a transaction restarts reception at the address byte.
- R9: `spread_en_o` is 1 when bits 1:0 of register 0 are not 00.
- R10: `sio_24m_o` equals bit 6 of register 3. A 1 selects 24 MHz and a 0 selects 48 MHz, which is the default.
- R11: `out_run_o[7:0]` equals register 1 and `out_run_o[15:8]` equals register 2. A 0 bit means that clock output is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| cfg_o | output | 64 | Eight configuration bytes, byte k at bits 8k+7:8k |
| spread_en_o | output | 1 | Spread-spectrum modulation enable |
| sio_24m_o | output | 1 | 1 selects 24 MHz, 0 selects 48 MHz |
| out_run_o | output | 16 | Per-output run mask; 0 holds that output low |

## Verification
The register commit for a data byte and the start of that byte's acknowledge drive happen in the same system-clock cycle. Every data byte sent during the table-driven transactions provokes this. While the slave holds the data line low in the ninth clock, the bench samples the configuration outputs and requires the new byte to be visible already. It then requires the line to be released after the ninth falling edge. Directed cases cover the paths that must not commit: a rejected address, a stop in the middle of a byte, a twelfth byte, and bytes clocked without a start.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    localparam int NUM_REGS   = 8;
    localparam int REG_W      = 8;
    localparam int REG_IDX_W  = $clog2(NUM_REGS);
    localparam int HDR_BYTES  = 3;
    localparam int BYTE_IDX_W = 4;
    localparam int BIT_CNT_W  = 4;
    localparam int CFG_W      = NUM_REGS * REG_W;

    localparam logic [REG_W-1:0]      DEV_ADDR = 8'hD2;
    localparam logic [BYTE_IDX_W-1:0] HDR_IDX  = BYTE_IDX_W'(HDR_BYTES);
    localparam logic [BYTE_IDX_W-1:0] LAST_IDX = BYTE_IDX_W'(HDR_BYTES + NUM_REGS - 1);
    localparam logic [BIT_CNT_W-1:0]  BITS_PER_BYTE = BIT_CNT_W'(REG_W);

    localparam int SS_REG     = 0;
    localparam int SIO_REG    = 3;
    localparam int SIO_BIT    = 6;
    localparam int RUN_LO_REG = 1;
    localparam int RUN_HI_REG = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic                 en;
        logic [REG_IDX_W-1:0] idx;
        logic [REG_W-1:0]     data;
    } reg_wr_t;

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        return (idx == RUN_LO_REG || idx == RUN_HI_REG) ? {REG_W{1'b1}} : '0;
    endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync
    import cfg_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    logic scl_now, scl_was, sda_now, sda_was;
    assign {scl_now, sda_now} = synced;
    assign {scl_was, sda_was} = prev;

    always_comb begin
        evt_o.rise  = scl_now & ~scl_was;
        evt_o.fall  = ~scl_now & scl_was;
        evt_o.start = scl_now & scl_was & sda_was & ~sda_now;
        evt_o.stop  = scl_now & scl_was & ~sda_was & sda_now;
        evt_o.sda   = sda_now;
    end

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    output logic     sda_low_o,
    output reg_wr_t  wr_o
);
    rx_state_e             state;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_IDX_W-1:0] byte_idx;
    logic [REG_W-1:0]      shreg;

    logic byte_done;
    logic take_byte;

    assign byte_done = (state == ST_RECV) && evt_i.fall && (bit_cnt == BITS_PER_BYTE)
                       && !evt_i.start && !evt_i.stop;
    assign take_byte = (byte_idx == '0) ? (shreg == DEV_ADDR) : (byte_idx <= LAST_IDX);

    always_comb begin
        wr_o.en   = byte_done && (byte_idx >= HDR_IDX) && (byte_idx <= LAST_IDX);
        wr_o.idx  = REG_IDX_W'(byte_idx - HDR_IDX);
        wr_o.data = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            shreg     <= '0;
            sda_low_o <= 1'b0;
        end else if (evt_i.start) begin
            state     <= ST_RECV;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            sda_low_o <= 1'b0;
        end else if (evt_i.stop) begin
            state     <= ST_IDLE;
            sda_low_o <= 1'b0;
        end else begin
            unique case (state)
                ST_RECV: begin
                    if (evt_i.rise && bit_cnt != BITS_PER_BYTE) begin
                        shreg   <= {shreg[REG_W-2:0], evt_i.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        if (take_byte) begin
                            state     <= ST_ACK;
                            sda_low_o <= 1'b1;
                        end else begin
                            state <= ST_DROP;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt_i.fall) begin
                        state     <= ST_RECV;
                        sda_low_o <= 1'b0;
                        bit_cnt   <= '0;
                        byte_idx  <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: the acknowledge stays on until the ninth falling edge
    a_r5_ack_held: assert property (@(posedge clk) disable iff (rst)
        (sda_low_o && !evt_i.fall && !evt_i.start && !evt_i.stop) |=> sda_low_o);

    // R5: the ninth falling edge releases the line
    a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
        (sda_low_o && evt_i.fall) |=> !sda_low_o);

    // R6: no acknowledge is ever started past the last data byte
    a_r6_no_ack_beyond: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low_o) |-> (byte_idx <= LAST_IDX));

    // R7: a stop returns the receiver to idle with the line released
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
        evt_i.stop |=> (state == ST_IDLE && !sda_low_o));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             spread_en_o,
    output logic             sio_24m_o,
    output logic [2*REG_W-1:0] out_run_o
);
    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= reg_default(g);
            else if (wr_i.en && wr_i.idx == REG_IDX_W'(g))
                regs[g] <= wr_i.data;
        end
        assign cfg_o[g*REG_W +: REG_W] = regs[g];
    end

    assign spread_en_o = |regs[SS_REG][1:0];
    assign sio_24m_o   = regs[SIO_REG][SIO_BIT];
    assign out_run_o   = {regs[RUN_HI_REG], regs[RUN_LO_REG]};

    // R4: a committed byte is visible in its register one cycle later
    a_r4_commit: assert property (@(posedge clk) disable iff (rst)
        wr_i.en |=> (regs[$past(wr_i.idx)] == $past(wr_i.data)));

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfg_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_low_o,
    output logic [63:0] cfg_o,
    output logic        spread_en_o,
    output logic        sio_24m_o,
    output logic [15:0] out_run_o
);
    bus_evt_t evt;
    reg_wr_t  wr;

    cfg_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    cfg_bus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .sda_low_o (sda_low_o),
        .wr_o      (wr)
    );

    cfg_reg_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr),
        .cfg_o       (cfg_o),
        .spread_en_o (spread_en_o),
        .sio_24m_o   (sio_24m_o),
        .out_run_o   (out_run_o)
    );

    // R6 / R2: the bank never changes while the slave is not in a write
    a_r2_no_write_while_idle: assert property (@(posedge clk) disable iff (rst)
        (!wr.en) |=> $stable(cfg_o));

endmodule

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_low_o;
    logic [63:0] cfg_o;
    logic        spread_en_o;
    logic        sio_24m_o;
    logic [15:0] out_run_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam int Q = 8;
    localparam logic [63:0] DEFAULTS = 64'h0000_0000_00FF_FF00;

    // {address, data0 .. data7}
    localparam logic [71:0] VEC [4] = '{
        {8'hD2, 8'h03, 8'hF0, 8'h0F, 8'h40, 8'h11, 8'h22, 8'h33, 8'h44},
        {8'hD3, 8'h01, 8'h00, 8'h00, 8'h40, 8'h55, 8'h66, 8'h77, 8'h88},
        {8'h52, 8'h02, 8'h12, 8'h34, 8'h40, 8'h99, 8'hAA, 8'hBB, 8'hCC},
        {8'hD2, 8'h00, 8'hA5, 8'h5A, 8'h00, 8'h00, 8'h01, 8'h80, 8'hFE}
    };

    assign sda_bus = m_sda & ~sda_low_o;

    always #10 clk = ~clk;

    cfg_serial_rx dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_low_o   (sda_low_o),
        .cfg_o       (cfg_o),
        .spread_en_o (spread_en_o),
        .sio_24m_o   (sio_24m_o),
        .out_run_o   (out_run_o)
    );

    logic [63:0] exp_cfg;
    logic [63:0] cfg_at_ack;
    logic        low_after;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic clock_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_q();
            m_scl = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        clock_bits(b, 8);
        m_sda = 1'b1; wait_q();
        acked      = ~sda_bus;
        cfg_at_ack = cfg_o;
        m_scl = 1'b1; wait_q();
        m_scl = 1'b0; wait_q();
        low_after = sda_low_o;
    endtask

    task automatic check_decode(input string req);
        check({req, " spread"}, 64'(spread_en_o), 64'(exp_cfg[1:0] != 2'b00));
        check({req, " sio"},    64'(sio_24m_o),   64'(exp_cfg[3*8+6]));
        check({req, " run"},    64'(out_run_o),   64'({exp_cfg[23:16], exp_cfg[15:8]}));
    endtask

    initial begin
        logic ack;
        logic match;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_q();

        // R1 reset defaults, R9 R10 R11 decode of defaults
        exp_cfg = DEFAULTS;
        check("R1 reset cfg", cfg_o, DEFAULTS);
        check("R1 reset sda idle", 64'(sda_low_o), 64'd0);
        check_decode("R9/R10/R11 defaults");

        // Table of full transactions: R2 R3 R4 R5
        foreach (VEC[v]) begin
            match = (VEC[v][71:64] == 8'hD2);
            bus_start();
            send_byte(VEC[v][71:64], ack);
            check("R2 address ack", 64'(ack), 64'(match));
            send_byte(8'hA5, ack);
            if (match) check("R3 command ack", 64'(ack), 64'd1);
            send_byte(8'h3C, ack);
            if (match) check("R3 count ack", 64'(ack), 64'd1);
            if (match) check("R3 header ignored", cfg_o, exp_cfg);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = VEC[v][63 - 8*k -: 8];
                send_byte(d, ack);
                check("R2/R4 data ack", 64'(ack), 64'(match));
                if (match) begin
                    exp_cfg[8*k +: 8] = d;
                    check("R4 commit during ack", cfg_at_ack, exp_cfg);
                    check("R5 release after ninth clock", 64'(low_after), 64'd0);
                end
            end
            bus_stop();
            wait_q();
            check("R2/R4 cfg after txn", cfg_o, exp_cfg);
            check_decode("R9/R10/R11 after txn");
        end

        // R6: byte after data byte 7
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h08, ack);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'h81 + 8'(k), ack);
            exp_cfg[8*k +: 8] = 8'h81 + 8'(k);
        end
        send_byte(8'hFF, ack);
        check("R6 twelfth byte ack", 64'(ack), 64'd0);
        check("R6 twelfth byte no change", cfg_o, exp_cfg);
        bus_stop();

        // R7: stop in the middle of data byte 1
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h08, ack);
        send_byte(8'h03, ack);
        exp_cfg[7:0] = 8'h03;
        clock_bits(8'h00, 4);
        bus_stop();
        wait_q();
        check("R7 partial byte dropped", cfg_o, exp_cfg);
        m_scl = 1'b0; wait_q();
        send_byte(8'h00, ack);
        check("R7 no ack without start", 64'(ack), 64'd0);
        check("R7 no change without start", cfg_o, exp_cfg);
        m_scl = 1'b1; wait_q();

        // R8: repeated start restarts at the address byte
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
        send_byte(8'hD2, ack);
        check("R8 address after restart", 64'(ack), 64'd1);
        send_byte(8'h00, ack);
        send_byte(8'h08, ack);
        send_byte(8'h00, ack);
        exp_cfg[7:0] = 8'h00;
        check("R8 data0 after restart", cfg_at_ack, exp_cfg);
        bus_stop();
        wait_q();
        check("R9 spread off", 64'(spread_en_o), 64'd0);

        // R1: reset returns defaults
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        wait_q();
        check("R1 reset after writes", cfg_o, DEFAULTS);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule